// File: doc/BRIEF.md
# Buffered SPI Master Shift Engine

This block is an SPI master that a processor drives through five small registers. One 16-bit register serves both directions: the bit at its top leaves on the serial output line while the bit sampled from the serial input enters at its bottom. A transfer moves a single character of 1 to 16 bits. The serial clock idles low. The output bit changes after each falling edge and the input bit is sampled on each rising edge. An active-low select stays low for the whole character.

Software starts a character in one of two ways. It can write the shift register directly, which starts at once when the engine is idle. It can also write the transmit holding register, whose value is copied into the shift register and sent as soon as the engine is free. Outgoing data must be left-aligned, because bits leave from the top. After the last bit, the whole shift register is copied into the receive register. The received bits end up right-aligned in its low positions, and the higher bits are whatever was shifted up from the old contents. A full flag is set at that point, an overrun flag records any lost character, and an interrupt line reports the full flag when enabled. The bit rate comes from a 7-bit divider field that gives 125 distinct rates.

Register map (addr_i): 0 = shift register, 1 = transmit holding, 2 = receive, 3 = control, 4 = status. Control: bits [3:0] hold the character length minus one, bits [10:4] the rate field, and bit 11 the interrupt enable. Status: bit 0 = receive full, bit 1 = overrun (write 1 to clear), bit 2 = busy, bit 3 = holding value pending.

Top module: `spi_host_shifter`

## Requirements
- R1: After reset, status reads 0, sclk_o is 0, cs_no is 1 and irq_o is 0.
- R2: Bits leave MSB first from bit 15 of the shift register. After an n-bit character, the receive register equals the old shift value shifted left by n, with the n received bits in bits n-1..0 (first received bit highest).
- R3: A character of length field L produces exactly L+1 rising sclk_o edges and a single low period on cs_no. sclk_o is low whenever cs_no is high.
- R4: With rate field v of 3 or more, one sclk_o period lasts v+1 clk_i cycles. Values 0, 1 and 2 give 4 cycles.
- R5: A write to address 0 while idle loads the shift register and starts a character. A write to address 0 while busy is ignored.
- R6: A write to address 1 sets the pending status bit. The held value is loaded and sent once the engine is idle, including after a character already in progress.
- R7: At the end of a character the receive register is updated and status bit 0 is set. Status bit 2 stays high until that copy has happened.
- R8: irq_o equals control bit 11 AND status bit 0.
- R9: Reading address 2 clears status bit 0. If a character completes in the same cycle as that read, the read returns the old value, bit 0 stays set and no overrun is recorded.
- R10: A character that completes while status bit 0 is set overwrites the receive register and sets status bit 1. Writing 1 to status bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_en_i | input | 1 | Register read strobe (enables read side effects) |
| rd_data_o | output | 16 | Register read data for addr_i |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Active-low select |
| irq_o | output | 1 | Interrupt request |

## Verification
The completion copy into the receive register and a processor read of that register can land on the same clock edge. The copy wants to set the full flag, and the read wants to clear it and, in the overrun logic, excuse the older character. The bench leaves one character unread and then launches a second one. It counts the clock edges of that second character exactly and raises the read strobe on the edge that performs the copy. It then expects the read to return the first character, the full flag to remain set, the overrun flag to stay clear, and a later read to return the second character.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } eng_state_e;

  localparam logic [2:0] A_SHIFT = 3'd0;
  localparam logic [2:0] A_HOLD  = 3'd1;
  localparam logic [2:0] A_RECV  = 3'd2;
  localparam logic [2:0] A_CTRL  = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;

  localparam int ST_FULL_BIT = 0;
  localparam int ST_OVR_BIT  = 1;
  localparam int ST_BUSY_BIT = 2;
  localparam int ST_PEND_BIT = 3;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int BAUD_W  = 7,
  parameter int MIN_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              rise_o,
  output logic              fall_o
);
  localparam int CW = BAUD_W + 1;

  logic [CW-1:0] div, lo_len, cnt_q;

  // small codes clamp to the minimum divider
  always_comb begin
    if (baud_i < BAUD_W'(MIN_DIV - 1)) div = CW'(MIN_DIV);
    else                               div = {1'b0, baud_i} + CW'(1);
    lo_len = div >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i)               cnt_q <= '0;
    else if (cnt_q >= div - CW'(1)) cnt_q <= '0;
    else                           cnt_q <= cnt_q + CW'(1);
  end

  assign rise_o = run_i && (cnt_q == lo_len - CW'(1));
  assign fall_o = run_i && (cnt_q == div - CW'(1));

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < div))
    else $error("a_r4_cnt_range");

  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0))
    else $error("a_r4_idle_zero");
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic [LEN_W-1:0]  len_m1_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              miso_i,
  output logic              run_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic [DATA_W-1:0] shreg_o,
  output logic              busy_o,
  output logic              done_o
);
  eng_state_e        state_q;
  logic [DATA_W-1:0] sh_q;
  logic [LEN_W-1:0]  bit_q, len_q;
  logic              sclk_q, cs_q, samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      len_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      samp_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sh_q    <= load_i;
          len_q   <= len_m1_i;
          bit_q   <= '0;
          cs_q    <= 1'b0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (rise_i) begin
            sclk_q <= 1'b1;
            samp_q <= miso_i;
          end
          if (fall_i) begin
            sclk_q <= 1'b0;
            sh_q   <= {sh_q[DATA_W-2:0], samp_q};
            if (bit_q == len_q) begin
              cs_q    <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              bit_q <= bit_q + LEN_W'(1);
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o   = (state_q == ST_SHIFT);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign sclk_o  = sclk_q;
  assign cs_no   = cs_q;
  assign mosi_o  = sh_q[DATA_W-1];
  assign shreg_o = sh_q;

  a_r3_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_SHIFT) |-> (cs_q && !sclk_q))
    else $error("a_r3_idle_lines");

  a_r3_bit_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (bit_q <= len_q))
    else $error("a_r3_bit_bound");

  a_r2_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !fall_i) |=> $stable(sh_q))
    else $error("a_r2_hold_between");

  a_r3_no_both_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && fall_i))
    else $error("a_r3_no_both_edges");
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BAUD_W = 7,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              irq_o
);
  localparam int LEN_W    = $clog2(DATA_W);
  localparam int BAUD_LSB = LEN_W;
  localparam int IEN_BIT  = LEN_W + BAUD_W;
  localparam int CTRL_W   = IEN_BIT + 1;

  logic [DATA_W-1:0] hold_q, recv_q, shreg;
  logic [CTRL_W-1:0] ctrl_q;
  logic              pend_q, full_q, ovr_q;
  logic              busy, done, run, rise, fall;
  logic              wr_shift, wr_hold, wr_ctrl, wr_stat, rd_recv;
  logic              start_cpu, start_buf, start;
  logic [DATA_W-1:0] load_val;

  assign wr_shift = wr_en_i && (addr_i == ADDR_W'(A_SHIFT));
  assign wr_hold  = wr_en_i && (addr_i == ADDR_W'(A_HOLD));
  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_stat  = wr_en_i && (addr_i == ADDR_W'(A_STAT));
  assign rd_recv  = rd_en_i && (addr_i == ADDR_W'(A_RECV));

  // a direct shift-register write wins over a pending held value
  assign start_cpu = wr_shift && !busy;
  assign start_buf = pend_q && !busy && !wr_shift;
  assign start     = start_cpu || start_buf;
  assign load_val  = start_cpu ? wr_data_i : hold_q;

  spi_baud_gen #(.BAUD_W(BAUD_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .baud_i (ctrl_q[BAUD_LSB +: BAUD_W]),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_shift_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .load_i   (load_val),
    .len_m1_i (ctrl_q[LEN_W-1:0]),
    .rise_i   (rise),
    .fall_i   (fall),
    .miso_i   (miso_i),
    .run_o    (run),
    .sclk_o   (sclk_o),
    .mosi_o   (mosi_o),
    .cs_no    (cs_no),
    .shreg_o  (shreg),
    .busy_o   (busy),
    .done_o   (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      if (wr_hold)   hold_q <= wr_data_i;
      if (wr_hold)   pend_q <= 1'b1;
      else if (start_buf) pend_q <= 1'b0;
      if (wr_ctrl)   ctrl_q <= wr_data_i[CTRL_W-1:0];
    end
  end

  // completion outranks a same-cycle read of the receive register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      recv_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (done) recv_q <= shreg;
      if (done)         full_q <= 1'b1;
      else if (rd_recv) full_q <= 1'b0;
      if (done && full_q && !rd_recv)         ovr_q <= 1'b1;
      else if (wr_stat && wr_data_i[ST_OVR_BIT]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      ADDR_W'(A_SHIFT): rd_data_o = shreg;
      ADDR_W'(A_HOLD):  rd_data_o = hold_q;
      ADDR_W'(A_RECV):  rd_data_o = recv_q;
      ADDR_W'(A_CTRL):  rd_data_o = DATA_W'(ctrl_q);
      ADDR_W'(A_STAT): begin
        rd_data_o[ST_FULL_BIT] = full_q;
        rd_data_o[ST_OVR_BIT]  = ovr_q;
        rd_data_o[ST_BUSY_BIT] = busy;
        rd_data_o[ST_PEND_BIT] = pend_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = ctrl_q[IEN_BIT] & full_q;

  a_r7_flag_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> full_q)
    else $error("a_r7_flag_on_done");

  a_r7_recv_captures: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (recv_q == $past(shreg)))
    else $error("a_r7_recv_captures");

  a_r10_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && full_q && !rd_recv) |=> ovr_q)
    else $error("a_r10_ovr_set");

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_recv && !done) |=> !full_q)
    else $error("a_r9_read_clears");

  a_r6_pend_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !busy) |=> busy)
    else $error("a_r6_pend_launch");

  a_r5_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done && wr_shift) |=> busy)
    else $error("a_r5_busy_ignores");
endmodule

// File: tb/sim_spi_host_shifter.sv
module sim_spi_host_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  logic        sclk, mosi, miso, cs_n, irq;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  spi_host_shifter u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n), .irq_o(irq)
  );

  // mode-0 slave model
  logic [15:0] slave_word = '0, slave_sh = '0, slave_rx = '0;
  assign miso = slave_sh[15];
  always @(negedge cs_n) slave_sh = slave_word;
  always @(posedge sclk) if (!cs_n) slave_rx = {slave_rx[14:0], mosi};
  always @(negedge sclk) if (!cs_n) slave_sh = {slave_sh[14:0], 1'b0};

  int clk_cnt = 0, npos = 0, t_last = 0, per = 0, cs_falls = 0;
  always @(posedge clk) clk_cnt = clk_cnt + 1;
  always @(posedge sclk) begin
    if (npos == 1) per = clk_cnt - t_last;
    t_last = clk_cnt;
    npos   = npos + 1;
  end
  always @(negedge cs_n) cs_falls = cs_falls + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    s = 16'h4;
    while (s[2] || s[3]) rd(3'd4, s);
  endtask

  function automatic logic [15:0] exp_rx(input logic [15:0] tx, input logic [15:0] sl, input int n);
    logic [31:0] t;
    t = ({16'h0, tx} << n) | ({16'h0, sl} >> (16 - n));
    return t[15:0];
  endfunction

  function automatic logic [15:0] exp_sl(input logic [15:0] tx, input int n);
    logic [31:0] m;
    m = (32'h1 << n) - 1;
    return 16'(({16'h0, tx} >> (16 - n)) & m);
  endfunction

  // {tx, slave, len-1, rate}
  localparam int NV = 6;
  localparam logic [42:0] VEC [NV] = '{
    {16'hA5C3, 16'h3C5A, 4'd15, 7'd3},
    {16'hFF80, 16'h6B00, 4'd8,  7'd5},
    {16'h8000, 16'hFFFF, 4'd0,  7'd0},
    {16'h1234, 16'hCAFE, 4'd7,  7'd10},
    {16'h0F0F, 16'hF0F0, 4'd11, 7'd2},
    {16'h7E81, 16'h9119, 4'd3,  7'd127}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, a_val;
    repeat (3) @(negedge clk);
    rd(3'd4, d);
    chk(d == 16'h0, "R1 status", d, 0);
    chk(sclk == 1'b0 && cs_n == 1'b1 && irq == 1'b0, "R1 lines", {sclk, cs_n, irq}, 3'b010);
    rst_n = 1'b1;
    rd(3'd4, d);
    chk(d == 16'h0, "R1 status after release", d, 0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] tx, sl;
      logic [3:0]  lm;
      logic [6:0]  bd;
      int n, dv, f0;
      {tx, sl, lm, bd} = VEC[i];
      n  = int'(lm) + 1;
      dv = (bd < 3) ? 4 : int'(bd) + 1;
      wr(3'd3, {5'd0, bd, lm});
      slave_word = sl;
      npos = 0; f0 = cs_falls;
      if (i % 2 == 0) wr(3'd0, tx);
      else            wr(3'd1, tx);
      wait_idle();
      rd(3'd2, d);
      chk(d == exp_rx(tx, sl, n), $sformatf("R2 recv vec%0d", i), d, exp_rx(tx, sl, n));
      chk(slave_rx[15:0] == exp_sl(tx, n) || (16'(slave_rx & 16'((32'h1 << n) - 1)) == exp_sl(tx, n)),
          $sformatf("R2 msb-first vec%0d", i), slave_rx, exp_sl(tx, n));
      chk(npos == n && cs_falls == f0 + 1, $sformatf("R3 edges vec%0d", i), npos, n);
      if (n >= 2) chk(per == dv, $sformatf("R4 period vec%0d", i), per, dv);
      rd(3'd4, d);
      chk(d[0] == 1'b0, $sformatf("R9 flag cleared vec%0d", i), d[0], 0);
    end

    // R7 busy through completion, flag set; R8 irq gating
    wr(3'd3, {5'd0, 7'd3, 4'd3});
    slave_word = 16'hC000;
    wr(3'd0, 16'h5000);
    rd(3'd4, d);
    chk(d[2] == 1'b1, "R7 busy during", d[2], 1);
    wait_idle();
    rd(3'd4, d);
    chk(d[0] == 1'b1 && d[2] == 1'b0, "R7 full set busy clear", d, 16'h1);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(3'd3, {4'd0, 1'b1, 7'd3, 4'd3});
    #1 chk(irq == 1'b1, "R8 irq asserted", irq, 1);
    rd(3'd2, d);
    chk(d == exp_rx(16'h5000, 16'hC000, 4), "R7 recv value", d, exp_rx(16'h5000, 16'hC000, 4));
    #1 chk(irq == 1'b0, "R8 R9 irq drops on read", irq, 0);
    wr(3'd3, {5'd0, 7'd3, 4'd7});

    // R5 write to shift register while busy is ignored
    slave_word = 16'h0000;
    wr(3'd0, 16'hB400);
    repeat (5) @(negedge clk);
    wr(3'd0, 16'h0055);
    wait_idle();
    chk(slave_rx[7:0] == 8'hB4, "R5 busy write ignored on line", slave_rx[7:0], 8'hB4);
    rd(3'd2, d);
    chk(d == exp_rx(16'hB400, 16'h0000, 8), "R5 recv unchanged", d, exp_rx(16'hB400, 16'h0000, 8));

    // R6 holding write queued behind an active character; R10 overrun
    slave_word = 16'hA100;
    wr(3'd0, 16'h1100);
    wr(3'd1, 16'h2200);
    rd(3'd4, d);
    chk(d[3] == 1'b1, "R6 pending set", d[3], 1);
    wait_idle();
    chk(slave_rx[15:0] == 16'h1122, "R6 queued sent after", slave_rx[15:0], 16'h1122);
    rd(3'd4, d);
    chk(d[1] == 1'b1 && d[0] == 1'b1, "R10 overrun set", d, 16'h3);
    rd(3'd2, d);
    chk(d == exp_rx(16'h2200, 16'hA100, 8), "R10 recv overwritten", d, exp_rx(16'h2200, 16'hA100, 8));
    wr(3'd4, 16'h0002);
    rd(3'd4, d);
    chk(d[1] == 1'b0, "R10 overrun cleared", d[1], 0);

    // R9 read lands on the completion edge
    wr(3'd3, {5'd0, 7'd3, 4'd3});
    slave_word = 16'h9000;
    wr(3'd0, 16'h3000);
    wait_idle();
    a_val = exp_rx(16'h3000, 16'h9000, 4);
    slave_word = 16'h6000;
    wr(3'd0, 16'hC000);
    repeat (16) @(negedge clk);
    addr = 3'd2; rd_en = 1'b1; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
    chk(d == a_val, "R9 collision returns old", d, a_val);
    rd(3'd4, d);
    chk(d[0] == 1'b1 && d[1] == 1'b0 && d[2] == 1'b0, "R9 collision flags", d, 16'h1);
    rd(3'd2, d);
    chk(d == exp_rx(16'hC000, 16'h6000, 4), "R9 collision new data", d, exp_rx(16'hC000, 16'h6000, 4));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule